// File: doc/BRIEF.md
# Channel Status Triple Buffer Manager

This block moves 24-word channel status blocks between a digital audio receiver and a transmitter. It keeps three buffers. The capture buffer is written word by word by the receive side. The staging buffer is the one the host reads and writes. The output buffer is read by the transmit side. A receive-side block event copies capture into staging. A transmit-side block event copies staging into output. The two events come from independent block timebases and may arrive in any cycle.

Each word holds two status bytes: channel A in bits 15:8 and channel B in bits 7:0. The host reaches the staging buffer a byte at a time. In paired mode it addresses each channel's byte separately. In single mode a write lands on both channels at once. The host can block either kind of copy. It can also protect the first five staging bytes from being overwritten by incoming blocks. When a block that is being sent is marked professional, the block replaces its last byte with a CRC check byte. A one-cycle interrupt pulse follows each completed copy.

Top module: `cs_tribuf`

## Requirements
- R1: After reset, all three buffers hold zero, `cpu_ready` is high and both interrupt outputs are low.
- R2: When `rx_blk` is sampled while idle and `cfg_inh_cs` is low, capture is copied into staging over the next 24 cycles, one word per cycle starting at word 0. `irq_cs` is high for exactly the one cycle after word 23 is written.
- R3: When `tx_blk` is sampled while idle and `cfg_inh_so` is low, staging is copied into output with the same timing. `irq_so` pulses for one cycle afterwards. The output buffer does not change outside such a copy, and `tx_rd_data` returns output word `tx_rd_addr`.
- R4: A block event sampled while its inhibit input is high is dropped. It is not remembered, and no copy or interrupt follows it later, even after the inhibit is released.
- R5: While `cfg_keep5` is high, a capture-to-staging copy leaves staging bytes 0 to 4 (words 0 to 4, both channels) unchanged.
- R6: During a staging-to-output copy, the byte of each channel in word 23 is replaced by that channel's CRC if bit 0 of the channel's byte in word 0 is 1. The CRC register starts at 0xFF and takes bytes 0 to 22 least significant bit first. For each input bit d, the feedback is crc[7] XOR d. The register shifts left by one, and when the feedback is 1 it is XORed with 0x1D.
- R7: With `cfg_pair` low, `cpu_addr[4:0]` is the byte index. A write stores `cpu_wdata` into both the A and the B byte of that word. A read returns the A byte.
- R8: With `cfg_pair` high, `cpu_addr[5:1]` is the byte index and `cpu_addr[0]` selects the channel (0 = A, 1 = B). Reads and writes touch only that one byte.
- R9: `cpu_ready` is low in every cycle of a copy. A host write held during a copy takes effect at the first clock edge at which `cpu_ready` is high. A read during a copy never shows a partially copied block once `cpu_ready` is high.
- R10: If both events are accepted in the same idle cycle, the staging-to-output copy runs first and the capture-to-staging copy starts in the cycle after it ends. An accepted event that arrives during a copy is held and served in the same order when the copy ends.
- R11: A byte index above 23 is ignored on write and reads as 0. An `rx_wr_addr` above 23 is ignored, and `tx_rd_data` is 0 for a `tx_rd_addr` above 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr_en | input | 1 | Capture buffer word write enable |
| rx_wr_addr | input | 5 | Capture word index |
| rx_wr_data | input | 16 | Capture word (A in 15:8, B in 7:0) |
| rx_blk | input | 1 | Receive block event, one cycle |
| tx_blk | input | 1 | Transmit block event, one cycle |
| tx_rd_addr | input | 5 | Output buffer word index |
| tx_rd_data | output | 16 | Output buffer word |
| cpu_req | input | 1 | Host access request |
| cpu_we | input | 1 | Host write (1) or read (0) |
| cpu_addr | input | 6 | Host byte address |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Host read byte from staging |
| cpu_ready | output | 1 | High when no copy is in progress |
| cfg_inh_cs | input | 1 | Inhibit capture-to-staging copies |
| cfg_inh_so | input | 1 | Inhibit staging-to-output copies |
| cfg_keep5 | input | 1 | Protect staging bytes 0 to 4 |
| cfg_pair | input | 1 | Paired (1) or single (0) byte mode |
| irq_cs | output | 1 | Capture-to-staging done pulse |
| irq_so | output | 1 | Staging-to-output done pulse |

## Verification
The copy engine is first driven with isolated receive and transmit events. It then sees both events in the same cycle, and finally an event that lands in the middle of the other copy. This separates the fixed transmit-first priority from plain first-come ordering. Incoming blocks are tried with protection on and off, and with inhibits raised before an event and cleared after it. A dropped event then shows up as staging or output contents that differ from what a remembered event would have produced. Professional marking is applied to channel A alone and then to both channels, which shows whether the CRC lanes are independent. Host writes are issued in single and paired mode, including one held through a copy and some out of range.

// File: rtl/cs_tribuf_pkg.sv
package cs_tribuf_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CS   = 2'd1,
    SQ_SO   = 2'd2
  } sq_t;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  // one byte through the check register, least significant bit first
  function automatic logic [7:0] crc_byte(input logic [7:0] crc_in, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[7] ^ d[b];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/cs_tribuf_rstsync.sv
module cs_tribuf_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/cs_tribuf_seq.sv
module cs_tribuf_seq
  import cs_tribuf_pkg::*;
#(
  parameter int WORDS = 24,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_cs,
  input  logic          ev_so,
  input  logic          inh_cs,
  input  logic          inh_so,
  output logic          busy,
  output logic          cs_act,
  output logic          so_act,
  output logic          so_start,
  output logic [AW-1:0] idx,
  output logic          last,
  output logic          irq_cs,
  output logic          irq_so
);
  localparam logic [AW-1:0] LAST_I = AW'(WORDS - 1);

  sq_t           st_q, st_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          pcs_q, pcs_d, pso_q, pso_d;
  logic          icq, icd, isq, isd;
  logic          ok_cs, ok_so;

  assign ok_cs = ev_cs & ~inh_cs;
  assign ok_so = ev_so & ~inh_so;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    pcs_d    = pcs_q;
    pso_d    = pso_q;
    icd      = 1'b0;
    isd      = 1'b0;
    so_start = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (ok_so || pso_q) begin
          st_d     = SQ_SO;
          idx_d    = '0;
          pso_d    = 1'b0;
          pcs_d    = pcs_q | ok_cs;
          so_start = 1'b1;
        end else if (ok_cs || pcs_q) begin
          st_d  = SQ_CS;
          idx_d = '0;
          pcs_d = 1'b0;
        end
      end
      default: begin
        pcs_d = pcs_q | ok_cs;
        pso_d = pso_q | ok_so;
        if (idx_q == LAST_I) begin
          st_d = SQ_IDLE;
          icd  = (st_q == SQ_CS);
          isd  = (st_q == SQ_SO);
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      pcs_q <= 1'b0;
      pso_q <= 1'b0;
      icq   <= 1'b0;
      isq   <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      pcs_q <= pcs_d;
      pso_q <= pso_d;
      icq   <= icd;
      isq   <= isd;
    end
  end

  assign busy   = (st_q != SQ_IDLE);
  assign cs_act = (st_q == SQ_CS);
  assign so_act = (st_q == SQ_SO);
  assign idx    = idx_q;
  assign last   = (idx_q == LAST_I);
  assign irq_cs = icq;
  assign irq_so = isq;

  // R2 R3
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_cs, irq_so}));

  // R2
  irq_cs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cs |=> !irq_cs);

  // R3
  irq_so_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_so |=> !irq_so);

  // R4
  inh_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inh_cs && !pcs_q) |=> !cs_act);

endmodule

// File: rtl/cs_tribuf_crc.sv
module cs_tribuf_crc
  import cs_tribuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_INIT;
    else if (en) crc_d = crc_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/cs_tribuf.sv
module cs_tribuf
  import cs_tribuf_pkg::*;
#(
  parameter int WORDS = 24,
  parameter int RSV   = 5,
  parameter int BW    = 8,
  parameter int AW    = $clog2(WORDS),
  parameter int WW    = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_wr_en,
  input  logic [AW-1:0] rx_wr_addr,
  input  logic [WW-1:0] rx_wr_data,
  input  logic          rx_blk,
  input  logic          tx_blk,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [WW-1:0] tx_rd_data,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW:0]   cpu_addr,
  input  logic [BW-1:0] cpu_wdata,
  output logic [BW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          cfg_inh_cs,
  input  logic          cfg_inh_so,
  input  logic          cfg_keep5,
  input  logic          cfg_pair,
  output logic          irq_cs,
  output logic          irq_so
);
  localparam logic [AW:0]   WORDS_W = (AW + 1)'(WORDS);
  localparam logic [AW-1:0] RSV_I   = AW'(RSV);

  logic          srst_n;
  logic          busy, cs_act, so_act, so_start, last;
  logic [AW-1:0] idx;
  logic [WW-1:0] cap_mem [WORDS];
  logic [WW-1:0] stg_mem [WORDS];
  logic [WW-1:0] out_mem [WORDS];
  logic [WW-1:0] stg_word, tail_word;
  logic [AW-1:0] hbyte;
  logic          hlow, hok, host_wr, rx_ok, cs_wr;

  cs_tribuf_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n));

  cs_tribuf_seq #(.WORDS(WORDS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(srst_n), .ev_cs(rx_blk), .ev_so(tx_blk),
    .inh_cs(cfg_inh_cs), .inh_so(cfg_inh_so), .busy(busy), .cs_act(cs_act),
    .so_act(so_act), .so_start(so_start), .idx(idx), .last(last),
    .irq_cs(irq_cs), .irq_so(irq_so));

  assign stg_word = stg_mem[idx];

  // one check lane per channel: lane 0 = A (upper byte), lane 1 = B
  for (genvar c = 0; c < 2; c++) begin : g_lane
    logic [BW-1:0] crc;
    logic          pro;
    cs_tribuf_crc u_crc (
      .clk(clk), .rst_n(srst_n), .clr(so_start), .en(so_act && !last),
      .din(stg_word[BW*(2-c)-1 -: BW]), .crc(crc));
    assign pro = stg_mem[0][BW*(1-c)];
    assign tail_word[BW*(2-c)-1 -: BW] = pro ? crc : stg_word[BW*(2-c)-1 -: BW];
  end

  // host byte decode
  assign hbyte     = cfg_pair ? cpu_addr[AW:1] : cpu_addr[AW-1:0];
  assign hlow      = cfg_pair & cpu_addr[0];
  assign hok       = ({1'b0, hbyte} < WORDS_W);
  assign cpu_ready = ~busy;
  assign host_wr   = cpu_req & cpu_we & cpu_ready & hok;
  assign rx_ok     = rx_wr_en & ({1'b0, rx_wr_addr} < WORDS_W);
  assign cs_wr     = cs_act & ~(cfg_keep5 & (idx < RSV_I));

  always_comb begin
    cpu_rdata = '0;
    if (hok) cpu_rdata = hlow ? stg_mem[hbyte][BW-1:0] : stg_mem[hbyte][WW-1:BW];
  end

  always_comb begin
    tx_rd_data = '0;
    if ({1'b0, tx_rd_addr} < WORDS_W) tx_rd_data = out_mem[tx_rd_addr];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < WORDS; i++) cap_mem[i] <= '0;
    end else if (rx_ok) begin
      cap_mem[rx_wr_addr] <= rx_wr_data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < WORDS; i++) stg_mem[i] <= '0;
    end else if (cs_wr) begin
      stg_mem[idx] <= cap_mem[idx];
    end else if (host_wr) begin
      if (!cfg_pair)  stg_mem[hbyte]          <= {cpu_wdata, cpu_wdata};
      else if (hlow)  stg_mem[hbyte][BW-1:0]  <= cpu_wdata;
      else            stg_mem[hbyte][WW-1:BW] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < WORDS; i++) out_mem[i] <= '0;
    end else if (so_act) begin
      out_mem[idx] <= last ? tail_word : stg_word;
    end
  end

  // R5
  keep5_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_keep5 && !host_wr) |=> $stable(stg_mem[0]));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !so_act |=> $stable(out_mem[WORDS-1]));

  // R9
  stall_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cs_act && !last) |=> !cpu_ready);

endmodule

// File: tb/cs_tribuf_test.sv
`timescale 1ns/1ps
module cs_tribuf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_wr_en, rx_blk, tx_blk, cpu_req, cpu_we;
  logic [4:0]  rx_wr_addr, tx_rd_addr;
  logic [15:0] rx_wr_data, tx_rd_data;
  logic [5:0]  cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_ready, cfg_inh_cs, cfg_inh_so, cfg_keep5, cfg_pair;
  logic        irq_cs, irq_so;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cs_tribuf uut (
    .clk(clk), .rst_n(rst_n), .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
    .rx_wr_data(rx_wr_data), .rx_blk(rx_blk), .tx_blk(tx_blk),
    .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cfg_inh_cs(cfg_inh_cs),
    .cfg_inh_so(cfg_inh_so), .cfg_keep5(cfg_keep5), .cfg_pair(cfg_pair),
    .irq_cs(irq_cs), .irq_so(irq_so));

  // ---------------- reference model ----------------
  int md[24], me[24], mf[24];
  int ms, mi, mca, mcb;
  bit mpc, mps, mic, mis;

  function automatic int crc_step(int c, int d);
    int r = c;
    for (int b = 0; b < 8; b++) begin
      int fb = ((r >> 7) ^ (d >> b)) & 1;
      r = (r << 1) & 255;
      if (fb != 0) r = r ^ 29;
    end
    return r;
  endfunction

  function automatic int h_byte();
    return cfg_pair ? int'(cpu_addr[5:1]) : int'(cpu_addr[4:0]);
  endfunction

  always @(posedge clk) begin
    bit okc, oks, hw;
    int hb, a, b;
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) begin md[i] = 0; me[i] = 0; mf[i] = 0; end
      ms = 0; mi = 0; mca = 255; mcb = 255; mpc = 0; mps = 0; mic = 0; mis = 0;
    end else begin
      okc = rx_blk && !cfg_inh_cs;
      oks = tx_blk && !cfg_inh_so;
      hw  = (ms == 0) && cpu_req && cpu_we;
      hb  = h_byte();
      mic = 0; mis = 0;
      if (ms == 0) begin
        if (oks || mps) begin
          ms = 2; mi = 0; mps = 0; mpc = mpc | okc; mca = 255; mcb = 255;
        end else if (okc || mpc) begin
          ms = 1; mi = 0; mpc = 0;
        end
      end else begin
        mpc = mpc | okc;
        mps = mps | oks;
        if (ms == 1) begin
          if (!(cfg_keep5 && mi < 5)) me[mi] = md[mi];
        end else begin
          a = (me[mi] >> 8) & 255;
          b = me[mi] & 255;
          if (mi < 23) begin
            mca = crc_step(mca, a);
            mcb = crc_step(mcb, b);
          end else begin
            if (((me[0] >> 8) & 1) != 0) a = mca;
            if ((me[0] & 1) != 0) b = mcb;
          end
          mf[mi] = (a << 8) | b;
        end
        if (mi == 23) begin
          mic = (ms == 1); mis = (ms == 2); ms = 0;
        end else mi++;
      end
      if (rx_wr_en && rx_wr_addr < 24) md[rx_wr_addr] = rx_wr_data;
      if (hw && hb < 24) begin
        if (!cfg_pair) me[hb] = (cpu_wdata << 8) | cpu_wdata;
        else if (cpu_addr[0]) me[hb] = (me[hb] & 16'hFF00) | cpu_wdata;
        else me[hb] = (me[hb] & 16'h00FF) | (cpu_wdata << 8);
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int hb, er, eo;
    if (rst_n) begin
      hb = h_byte();
      er = 0;
      if (hb < 24) er = (cfg_pair && cpu_addr[0]) ? (me[hb] & 255) : ((me[hb] >> 8) & 255);
      eo = (tx_rd_addr < 24) ? mf[tx_rd_addr] : 0;
      cmp("ready", int'(cpu_ready), int'(ms == 0));
      cmp("irq_cs", int'(irq_cs), int'(mic));
      cmp("irq_so", int'(irq_so), int'(mis));
      cmp("rdata", int'(cpu_rdata), er);
      cmp("tx_rd", int'(tx_rd_data), eo);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #2;
    tx_rd_addr = (tx_rd_addr >= 5'd23) ? 5'd0 : tx_rd_addr + 5'd1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_rx(); rx_blk = 1; tick(); rx_blk = 0; endtask
  task automatic pulse_tx(); tx_blk = 1; tick(); tx_blk = 0; endtask

  task automatic fill_cap(int seed);
    for (int w = 0; w < 24; w++) begin
      rx_wr_en = 1; rx_wr_addr = 5'(w);
      rx_wr_data = {8'((w * 6 + seed) & 8'hFE), 8'((w * 10 + seed * 3) & 8'hFE)};
      tick();
    end
    rx_wr_en = 0;
  endtask

  task automatic hwrite(int addr, int data);
    bit r;
    cpu_req = 1; cpu_we = 1; cpu_addr = 6'(addr); cpu_wdata = 8'(data);
    forever begin
      r = cpu_ready;
      tick();
      if (r) break;
    end
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic sweep_read(int n);
    for (int a = 0; a < n; a++) begin cpu_addr = 6'(a); tick(); end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; rx_wr_en = 0; rx_blk = 0; tx_blk = 0; cpu_req = 0; cpu_we = 0;
    rx_wr_addr = 0; rx_wr_data = 0; tx_rd_addr = 0; cpu_addr = 0; cpu_wdata = 0;
    cfg_inh_cs = 0; cfg_inh_so = 0; cfg_keep5 = 0; cfg_pair = 1;
    ticks(3);
    rst_n = 1;
    // R1 reset state: outputs, staging reads and output sweep all zero
    cur_req = "R1"; ticks(4); sweep_read(48);
    // R2 capture-to-staging copy
    cur_req = "R2"; fill_cap(2); pulse_rx(); ticks(30); sweep_read(48);
    // R3 staging-to-output copy, then output sweep
    cur_req = "R3"; pulse_tx(); ticks(30); ticks(26);
    // R6 professional mark on channel A only, then on both
    cur_req = "R6"; hwrite(0, 8'h01); pulse_tx(); ticks(30); ticks(26);
    hwrite(1, 8'h25); hwrite(20, 8'h9C); pulse_tx(); ticks(30); ticks(26);
    // R7 single mode: write both channels, read A
    cur_req = "R7"; cfg_pair = 0; hwrite(5, 8'hA5); hwrite(23, 8'h3C); hwrite(0, 8'h00);
    sweep_read(24); cfg_pair = 1; sweep_read(48); cfg_pair = 0;
    // R8 paired mode: independent bytes
    cur_req = "R8"; cfg_pair = 1; hwrite(11, 8'h5A); hwrite(12, 8'hC3); hwrite(47, 8'h77);
    sweep_read(48); pulse_tx(); ticks(30); ticks(26);
    // R11 out-of-range addresses
    cur_req = "R11"; cfg_pair = 0; hwrite(30, 8'hEE); cpu_addr = 6'd30; tick();
    cfg_pair = 1; hwrite(61, 8'hEE); sweep_read(64);
    rx_wr_en = 1; rx_wr_addr = 5'd28; rx_wr_data = 16'hFFFF; tick(); rx_wr_en = 0;
    tx_rd_addr = 5'd26; tick(); ticks(3);
    // R5 protected first five bytes
    cur_req = "R5"; cfg_pair = 0;
    for (int k = 0; k < 5; k++) hwrite(k, 8'h40 + k);
    cfg_pair = 1; cfg_keep5 = 1; fill_cap(9); pulse_rx(); ticks(30); sweep_read(48);
    cfg_keep5 = 0; pulse_rx(); ticks(30); sweep_read(12);
    // R4 inhibits drop events
    cur_req = "R4"; cfg_inh_cs = 1; fill_cap(17); pulse_rx(); ticks(3); cfg_inh_cs = 0;
    ticks(30); sweep_read(48);
    cfg_inh_so = 1; hwrite(3, 8'h66); pulse_tx(); ticks(3); cfg_inh_so = 0; ticks(30); ticks(26);
    // R10 same-cycle events and events during a copy
    cur_req = "R10"; fill_cap(33); hwrite(0, 8'h81);
    rx_blk = 1; tx_blk = 1; tick(); rx_blk = 0; tx_blk = 0; ticks(60); sweep_read(48); ticks(26);
    fill_cap(41); pulse_tx(); ticks(5); pulse_rx(); ticks(60);
    pulse_rx(); ticks(4); pulse_tx(); ticks(60); sweep_read(48); ticks(26);
    // R9 host write held through a copy lands when ready
    cur_req = "R9"; fill_cap(55); pulse_rx(); hwrite(7, 8'hB4); sweep_read(16);
    pulse_tx(); cpu_addr = 6'd2; ticks(10); hwrite(2, 8'h1E); ticks(30); ticks(26);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule